// File: doc/BRIEF.md
# Clocked Serial I/O Shifter

This block is an eight-bit synchronous serial port for a small microcontroller. The processor writes a byte into the shift register to start a transfer. The block then moves one bit out on every falling edge of the transfer clock and takes one bit in on every rising edge. After eight bits it raises an interrupt request. A mode byte picks the bit order and the source of the transfer clock. The clock can come from an internal divider, with the block driving the clock pin, or from an external master, with the block sampling the pin.

In internal mode the transfer clock toggles every `DIV` system-clock cycles. The transfer stops after eight cycles with the clock parked high and the data output released. In external mode the pin passes through a two-flop synchronizer and an edge detector. The interrupt is raised after eight counted rising edges, but shifting goes on for as long as the external master keeps clocking. The external clock therefore has to be much slower than the system clock. It must also be high whenever the processor writes the shift register. The clock source must not be changed during a transfer, and after a change the shift register has to be written again to restart the counter.

Top module: `csio_shifter`

## Requirements
- R1: After reset `sclk_out` is 1, `sdo_oe` is 0, `irq` is 0, and `shift_q` and `mode_q` are both 0.
- R2: A cycle with `cpu_wr` high loads `cpu_wdata` into the shift register and sets the remaining-bit counter to 7. From the next cycle `sclk_out` is 1 and `sdo_oe` is 1.
- R3: Each falling transfer-clock edge puts the next bit on `sdo`. With `mode_q[5]`=0 the bits go out in the order bit 0 to bit 7.
- R4: Each rising transfer-clock edge samples `sdi` and shifts the register by one bit. With `mode_q[5]`=0 the bit taken in first ends up in bit 0 after eight rising edges.
- R5: With `mode_q[0]`=0, the eighth rising edge ends the transfer and sets `irq` to 1, and `sclk_out` stays 1 afterwards.
- R6: With `mode_q[0]`=0, `sdo_oe` drops to 0 when the transfer ends. `shift_q` then holds the received byte unchanged until the next write.
- R7: Once `irq` is set it stays at 1 until a cycle with `irq_clr` high, which clears it.
- R8: With `mode_q[5]`=1 (MSB first), bit 7 goes out first and the bit taken in first ends up in bit 7.
- R9: In internal mode each half period of `sclk_out` lasts `DIV` system cycles. From the write cycle until `irq` rises takes 16*`DIV` cycles.
- R10: With `mode_q[0]`=1, edges on `sclk_in` drive the shifting. `irq` is still 0 after seven rising edges and becomes 1 after the eighth.
- R11: In external mode, rising edges after the eighth keep shifting `sdi` into the register, while `irq` and `sdo_oe` both stay at 1.
- R12: In external mode `sclk_oe` is 0 and `sclk_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write strobe for the shift register; starts a transfer |
| cpu_wdata | input | 8 | Byte written into the shift register |
| mode_wr | input | 1 | Write strobe for the mode byte |
| mode_wdata | input | 8 | Mode byte: bit 0 selects the external clock, bit 5 selects MSB first |
| irq_clr | input | 1 | Clears the interrupt request |
| sclk_in | input | 1 | External transfer clock, sampled in external mode |
| sdi | input | 1 | Serial data input |
| shift_q | output | 8 | Current shift-register contents |
| mode_q | output | 8 | Current mode byte |
| irq | output | 1 | Interrupt request: eight bits have been counted |
| sclk_out | output | 1 | Internal transfer clock |
| sclk_oe | output | 1 | Output enable for the transfer-clock pin |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for the serial data pin |

## Verification
The bench counts the cycles from a write to the interrupt. A divider that is off by one, or that starts without first forcing the clock high, shows up as a wrong total. Every falling edge is compared against a queue of expected output bits in both bit orders, so a reversed order or a missing or extra edge leaves the queue mismatched. In external mode the interrupt is checked after the seventh rising edge, where a counter that fires one edge early would already have raised it. Two extra edges are then applied after the interrupt, which catches a design that wrongly stops shifting or releases the data pin.

// File: rtl/csio_pkg.sv
package csio_pkg;

    localparam int DATA_W  = 8;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int EXT_BIT = 0;
    localparam int MSB_BIT = 5;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic active;
        cnt_t left;
    } xfer_t;

    function automatic logic out_bit(input data_t q, input logic msb_first);
        return msb_first ? q[DATA_W-1] : q[0];
    endfunction

    function automatic data_t shift_in(input data_t q, input logic msb_first, input logic din);
        return msb_first ? {q[DATA_W-2:0], din} : {din, q[DATA_W-1:1]};
    endfunction

endpackage

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic sclk,
    output logic fall,
    output logic rise
);
    localparam int DIV_W = $clog2(DIV + 1);

    logic [DIV_W-1:0] div_q;
    logic             wrap;

    assign wrap = run && (div_q == DIV_W'(DIV - 1));
    assign fall = wrap && sclk;
    assign rise = wrap && !sclk;

    always_ff @(posedge clk) begin
        if (rst || start || !run) begin
            div_q <= '0;
            sclk  <= 1'b1;
        end else if (wrap) begin
            div_q <= '0;
            sclk  <= ~sclk;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/csio_edge.sv
module csio_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    assign rise = sync_q && !prev_q;
    assign fall = !sync_q && prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/csio_shreg.sv
module csio_shreg
    import csio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  data_t ldata,
    input  logic  fall,
    input  logic  rise,
    input  logic  msb_first,
    input  logic  din,
    output data_t q,
    output logic  dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            dout <= 1'b1;
        end else if (load) begin
            q <= ldata;
        end else begin
            if (fall) dout <= out_bit(q, msb_first);
            if (rise) q    <= shift_in(q, msb_first, din);
        end
    end
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter
    import csio_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    input  logic              irq_clr,
    input  logic              sclk_in,
    input  logic              sdi,
    output logic [DATA_W-1:0] shift_q,
    output logic [7:0]        mode_q,
    output logic              irq,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdo,
    output logic              sdo_oe
);
    xfer_t xfer;
    logic  ext, msb, run;
    logic  ifall, irise, efall, erise, fall, rise;

    assign ext     = mode_q[EXT_BIT];
    assign msb     = mode_q[MSB_BIT];
    assign run     = xfer.active && !ext;
    assign fall    = ext ? efall : ifall;
    assign rise    = ext ? erise : irise;
    assign sclk_oe = !ext;

    csio_clkgen #(.DIV(DIV)) u_clkgen (
        .clk(clk), .rst(rst), .start(cpu_wr), .run(run),
        .sclk(sclk_out), .fall(ifall), .rise(irise)
    );

    csio_edge u_edge (
        .clk(clk), .rst(rst), .pin(sclk_in), .fall(efall), .rise(erise)
    );

    csio_shreg u_shreg (
        .clk(clk), .rst(rst), .load(cpu_wr), .ldata(cpu_wdata),
        .fall(fall), .rise(rise), .msb_first(msb), .din(sdi),
        .q(shift_q), .dout(sdo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer   <= '0;
            irq    <= 1'b0;
            sdo_oe <= 1'b0;
            mode_q <= '0;
        end else begin
            if (mode_wr) mode_q <= mode_wdata;
            if (irq_clr) irq <= 1'b0;
            if (cpu_wr) begin
                xfer.active <= 1'b1;
                xfer.left   <= cnt_t'(DATA_W - 1);
                sdo_oe      <= 1'b1;
            end else if (rise && xfer.active) begin
                if (xfer.left == '0) begin
                    xfer.active <= 1'b0;
                    irq         <= 1'b1;
                    if (!ext) sdo_oe <= 1'b0;
                end else begin
                    xfer.left <= xfer.left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/csio_checker.sv
module csio_checker (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic       irq_clr,
    input logic       run,
    input logic       sclk_out,
    input logic       sdo_oe,
    input logic       irq,
    input logic [7:0] shift_q,
    input logic [7:0] mode_q
);
    AST_WR_FORCES_HIGH: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |=> sclk_out); // R2

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        ($fell(run) && !mode_q[0]) |-> irq); // R5

    AST_DONE_RELEASES_SDO: assert property (@(posedge clk) disable iff (rst)
        ($fell(run) && !mode_q[0]) |-> !sdo_oe); // R6

    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (!run && !mode_q[0] && !cpu_wr) |=> $stable(shift_q)); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R7

    AST_EXT_CLOCK_PARKED: assert property (@(posedge clk) disable iff (rst)
        (mode_q[0] && $past(mode_q[0])) |-> sclk_out); // R12
endmodule

bind csio_shifter csio_checker u_checker (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .irq_clr(irq_clr), .run(run),
    .sclk_out(sclk_out), .sdo_oe(sdo_oe), .irq(irq), .shift_q(shift_q),
    .mode_q(mode_q)
);

// File: tb/test_csio_shifter.sv
module test_csio_shifter;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       irq_clr = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sdi;
    logic       mon_sdi = 1'b0;
    logic       ext_sdi = 1'b0;
    logic       use_ext = 1'b0;
    logic [7:0] shift_q, mode_q;
    logic       irq, sclk_out, sclk_oe, sdo, sdo_oe;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    exp_q[$];
    bit    rx_q[$];
    string cur_tag = "R3";
    logic  prev_sclk = 1'b1;

    assign sdi = use_ext ? ext_sdi : mon_sdi;

    always #4 clk = ~clk;

    csio_shifter #(.DIV(DIV)) i_csio_shifter (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .irq_clr(irq_clr),
        .sclk_in(sclk_in), .sdi(sdi), .shift_q(shift_q), .mode_q(mode_q),
        .irq(irq), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo),
        .sdo_oe(sdo_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: on each internal falling edge compare sdo, then present the next input bit
    always @(negedge clk) begin
        if (!rst && prev_sclk && !sclk_out && sclk_oe) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected falling edge"}, 32'd1, 32'd0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(sdo == e, {cur_tag, " sdo bit"}, 32'(sdo), 32'(e));
            end
            if (rx_q.size() != 0) mon_sdi <= rx_q.pop_front();
        end
        prev_sclk <= sclk_out;
    end

    task automatic set_mode(input logic [7:0] m);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    // Driver: queue the expected serial bits, start the transfer, check the end state
    task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rx, input bit msb, input string tag);
        int cycles;
        cur_tag = tag;
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(msb ? tx[7-i] : tx[i]);
            rx_q.push_back(msb ? rx[7-i] : rx[i]);
        end
        @(negedge clk); cpu_wr = 1'b1; cpu_wdata = tx;
        @(negedge clk); cpu_wr = 1'b0;
        chk(sclk_out == 1'b1, "R2 clock forced high", 32'(sclk_out), 32'd1);
        chk(sdo_oe == 1'b1, "R2 output enabled", 32'(sdo_oe), 32'd1);
        cycles = 1;
        while (!irq && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
        chk(cycles == 16*DIV + 1, "R9 transfer length", 32'(cycles), 32'(16*DIV + 1));
        chk(irq == 1'b1, "R5 irq set", 32'(irq), 32'd1);
        chk(shift_q == rx, {tag, " received byte"}, 32'(shift_q), 32'(rx));
        chk(sclk_out == 1'b1, "R5 clock idle high", 32'(sclk_out), 32'd1);
        chk(sdo_oe == 1'b0, "R6 sdo released", 32'(sdo_oe), 32'd0);
        chk(exp_q.size() == 0, "R3 all bits sent", 32'(exp_q.size()), 32'd0);
        repeat (3*DIV) @(negedge clk);
        chk(shift_q == rx, "R6 data held", 32'(shift_q), 32'(rx));
        chk(irq == 1'b1, "R7 irq held", 32'(irq), 32'd1);
        clear_irq();
        chk(irq == 1'b0, "R7 irq cleared", 32'(irq), 32'd0);
    endtask

    task automatic ext_edge(input logic d);
        sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        ext_sdi = d;
        sclk_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [7:0] tx, rx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk_out == 1'b1, "R1 sclk_out", 32'(sclk_out), 32'd1);
        chk(sdo_oe == 1'b0, "R1 sdo_oe", 32'(sdo_oe), 32'd0);
        chk(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
        chk(shift_q == 8'h00, "R1 shift_q", 32'(shift_q), 32'd0);
        chk(mode_q == 8'h00, "R1 mode_q", 32'(mode_q), 32'd0);

        xfer_int(8'hA5, 8'h3C, 1'b0, "R4");
        xfer_int(8'h01, 8'h80, 1'b0, "R4");
        set_mode(8'h20);
        chk(mode_q == 8'h20, "R8 mode readback", 32'(mode_q), 32'h20);
        xfer_int(8'h96, 8'hC3, 1'b1, "R8");
        xfer_int(8'h80, 8'h01, 1'b1, "R8");

        // External clock, LSB first
        set_mode(8'h01);
        use_ext = 1'b1;
        chk(sclk_oe == 1'b0, "R12 clock pin released", 32'(sclk_oe), 32'd0);
        chk(sclk_out == 1'b1, "R12 clock parked", 32'(sclk_out), 32'd1);
        tx = 8'h5A; rx = 8'hB4;
        @(negedge clk); cpu_wr = 1'b1; cpu_wdata = tx;
        @(negedge clk); cpu_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
            chk(sdo == tx[i], "R10 ext sdo bit", 32'(sdo), 32'(tx[i]));
            if (i == 7) chk(irq == 1'b0, "R10 no irq after 7", 32'(irq), 32'd0);
            ext_sdi = rx[i];
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk(irq == 1'b1, "R10 irq after 8", 32'(irq), 32'd1);
        chk(shift_q == rx, "R10 ext received", 32'(shift_q), 32'(rx));
        ext_edge(1'b1);
        ext_edge(1'b1);
        chk(shift_q == {2'b11, rx[7:2]}, "R11 shifting continues", 32'(shift_q), 32'({2'b11, rx[7:2]}));
        chk(irq == 1'b1, "R11 irq stays", 32'(irq), 32'd1);
        chk(sdo_oe == 1'b1, "R11 sdo stays enabled", 32'(sdo_oe), 32'd1);
        chk(sclk_out == 1'b1, "R12 clock stays parked", 32'(sclk_out), 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule